// File: doc/BRIEF.md
# Host Bridge to a Coprocessor Shared Memory

This block sits on a 16-bit host I/O bus and gives the host everything it needs to drive a coprocessor card: a 2048-word by 32-bit shared memory, a control latch for the coprocessor's reset, interrupt, hold and boot-loader lines, a one-bit ownership semaphore that decides who may use the shared memory, and a two-way service-request mailbox. Eight registers sit at even byte offsets. A 32-bit memory address and a 32-bit data word are each moved as two 16-bit halves.

The coprocessor is represented by a handful of ports. It holds a level request for the shared memory, sees its grant, pulses an acknowledge for the host's service request, and pulses a request of its own toward the host. Reads return data combinationally in the cycle the read strobe is high. Writes take effect at the clock edge that ends the write cycle.

Top module: `hostdsp_bridge`

## Requirements
- R1: `bus_addr` carries byte offset bits 3:1. The registers are: 0 address high, 2 address low, 4 data high, 6 data low, 8 control, 10 semaphore, 12 service request, 14 acknowledge. `bus_rdata` is zero when `bus_rd` is low, and reading offset 14 returns zero.
- R2: Offsets 0 and 2 store and read back the high and low halves of a 32-bit address. The memory word index is the low 11 bits of that address, so the high half has no effect on which word is selected.
- R3: Writing offset 4 stores the upper data half. Writing offset 6 while the host holds the grant writes {stored upper half, written lower half} into the word selected by the address.
- R4: Reading offset 4 with the grant returns bits 31:16 of the addressed word and captures the whole word. A later read of offset 6 returns bits 15:0 of the captured word, even if memory was changed in between. A read reflects address and data writes that completed at least two cycles earlier.
- R5: Without the host grant, a write to offset 6 leaves memory unchanged, and reads of offsets 4 and 6 return zero.
- R6: Writing offset 8 loads an 8-bit control value, which reads back at offset 8. Bit 0 drives `cp_reset`, bit 4 drives `cp_ei2`, bit 5 drives `cp_hold` and bit 7 drives `cp_boot`. Reset loads 0x13, so the coprocessor starts halted.
- R7: Writing offset 10 with bit 0 = 1 requests the shared memory, and bit 0 = 0 releases it. Reading offset 10 bit 0 returns 1 when the host holds the grant. The grant changes at the clock edge that ends the write.
- R8: If the coprocessor holds `cp_mem_req` while the host does not own the memory, the coprocessor gets it, and this holds also when both ask in the same cycle. A pending host request is granted in the cycle after the coprocessor drops its request. A host that already holds the grant keeps it until it releases.
- R9: A write to offset 12 latches bit 0 as the host request (`cp_srq_out`, readable at bit 0 of offset 12). A pulse on `cp_srq_ack` clears it. A host write in the same cycle as the pulse takes precedence.
- R10: A pulse on `cp_srq_req` sets the coprocessor request (`host_irq`, readable at bit 1 of offset 12). Any write to offset 14 clears it. A request pulse in the same cycle as that write takes precedence, so the request is kept.
- R11: The host grant and `cp_mem_grant` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Host write strobe for one cycle |
| bus_rd | input | 1 | Host read strobe for one cycle |
| bus_addr | input | 3 | Byte offset bits 3:1 |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, valid while bus_rd is high |
| cp_mem_req | input | 1 | Coprocessor holds this high to claim the shared memory |
| cp_srq_ack | input | 1 | Coprocessor pulse that acknowledges the host request |
| cp_srq_req | input | 1 | Coprocessor pulse that raises a request to the host |
| cp_reset | output | 1 | Coprocessor reset, active high |
| cp_ei2 | output | 1 | Coprocessor interrupt line |
| cp_hold | output | 1 | Coprocessor hold request |
| cp_boot | output | 1 | Coprocessor boot-loader mode |
| cp_mem_grant | output | 1 | Coprocessor owns the shared memory |
| cp_srq_out | output | 1 | Pending host-to-coprocessor request |
| host_irq | output | 1 | Pending coprocessor-to-host request |

## Verification
Three functions can land in the same cycle. In each case the bench provokes the collision on purpose and then reads the result back through offset 10 or offset 12.

- A host write to offset 12 together with a `cp_srq_ack` pulse: the written bit must survive.
- A `cp_srq_req` pulse together with a host write to offset 14: the coprocessor request must survive.
- A host semaphore request in the same cycle that `cp_mem_req` rises: the coprocessor must win, and the host grant must follow one cycle after the coprocessor lets go.

A behavioural reference model in the bench judges every cycle's outputs and every read.

// File: rtl/hdb_pkg.sv
// Package: register selects, ownership states and control bit positions
// shared by the bridge, its submodules and its checker.
package hdb_pkg;

    typedef enum logic [2:0] {
        SEL_ADDR_HI = 3'd0,
        SEL_ADDR_LO = 3'd1,
        SEL_DATA_HI = 3'd2,
        SEL_DATA_LO = 3'd3,
        SEL_CTRL    = 3'd4,
        SEL_SEM     = 3'd5,
        SEL_SRQ     = 3'd6,
        SEL_ACK     = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        OWNER_NONE = 2'd0,
        OWNER_HOST = 2'd1,
        OWNER_CP   = 2'd2
    } owner_e;

    localparam int CTRL_RST_BIT  = 0;
    localparam int CTRL_EI2_BIT  = 4;
    localparam int CTRL_HOLD_BIT = 5;
    localparam int CTRL_BOOT_BIT = 7;

endpackage

// File: rtl/hdb_dpram.sv
// Module: synchronous single-clock memory for the shared window.
// Assumes: the read address is sampled every clock; a write and a read
// of the same word in one cycle return the old contents (read first).
module hdb_dpram #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Purpose: registered read of the addressed word, optional write.
    always_ff @(posedge clk) begin
        q <= store[addr];
        if (we) begin
            store[addr] <= wdata;
        end
    end
endmodule

// File: rtl/hdb_sem.sv
// Module: ownership semaphore for the shared memory.
// Assumes: the host request is a sticky flag set or cleared by a register
// write; the coprocessor request is a level. The coprocessor wins when the
// memory is free, and a host that owns the memory keeps it until it releases.
module hdb_sem
    import hdb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_wr,
    input  logic req_val,
    input  logic cp_req,
    output logic host_grant,
    output logic cp_grant
);
    logic   want_q;
    logic   want_nx;
    owner_e owner_q;
    owner_e owner_nx;

    // Purpose: the host request value that will apply after this edge.
    always_comb begin
        want_nx = req_wr ? req_val : want_q;
    end

    // Purpose: next owner from the current owner and both requests.
    always_comb begin
        owner_nx = owner_q;
        unique case (owner_q)
            OWNER_NONE: owner_nx = cp_req ? OWNER_CP
                                 : (want_nx ? OWNER_HOST : OWNER_NONE);
            OWNER_HOST: owner_nx = want_nx ? OWNER_HOST
                                 : (cp_req ? OWNER_CP : OWNER_NONE);
            OWNER_CP:   owner_nx = cp_req ? OWNER_CP
                                 : (want_nx ? OWNER_HOST : OWNER_NONE);
            default:    owner_nx = OWNER_NONE;
        endcase
    end

    // Purpose: hold the request flag and the owner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            want_q  <= 1'b0;
            owner_q <= OWNER_NONE;
        end else begin
            want_q  <= want_nx;
            owner_q <= owner_nx;
        end
    end

    assign host_grant = (owner_q == OWNER_HOST);
    assign cp_grant   = (owner_q == OWNER_CP);
endmodule

// File: rtl/hdb_mbox.sv
// Module: two-direction service-request mailbox.
// Assumes: all inputs are single-cycle pulses. In the host-to-coprocessor
// direction a host write beats a simultaneous acknowledge. In the other
// direction a new request beats a simultaneous host clear.
module hdb_mbox (
    input  logic clk,
    input  logic rst_n,
    input  logic srq_wr,
    input  logic srq_val,
    input  logic cp_ack,
    input  logic ack_wr,
    input  logic cp_req_pulse,
    output logic host_srq,
    output logic cp_srq
);
    // Purpose: host-to-coprocessor request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_srq <= 1'b0;
        end else if (srq_wr) begin
            host_srq <= srq_val;
        end else if (cp_ack) begin
            host_srq <= 1'b0;
        end
    end

    // Purpose: coprocessor-to-host request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cp_srq <= 1'b0;
        end else if (cp_req_pulse) begin
            cp_srq <= 1'b1;
        end else if (ack_wr) begin
            cp_srq <= 1'b0;
        end
    end
endmodule

// File: rtl/hostdsp_bridge.sv
// Module: host register file in front of the coprocessor shared memory.
// Assumes: one host access per cycle with reads combinational. The memory
// reads the word at the latched address every clock, so a data read sees
// writes completed two or more cycles earlier. MEM_AW must not exceed HALF_W.
module hostdsp_bridge
    import hdb_pkg::*;
#(
    parameter int          HALF_W     = 16,
    parameter int          MEM_AW     = 11,
    parameter int          CTRL_W     = 8,
    parameter logic [7:0]  CTRL_RESET = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [3:1]        bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    input  logic              cp_mem_req,
    input  logic              cp_srq_ack,
    input  logic              cp_srq_req,
    output logic              cp_reset,
    output logic              cp_ei2,
    output logic              cp_hold,
    output logic              cp_boot,
    output logic              cp_mem_grant,
    output logic              cp_srq_out,
    output logic              host_irq
);
    localparam int DATA_W  = 2 * HALF_W;
    localparam int N_REGS  = 8;

    logic [N_REGS-1:0] wr_hit;
    logic              rd_data_hi;
    logic [HALF_W-1:0] addr_hi_q;
    logic [HALF_W-1:0] addr_lo_q;
    logic [HALF_W-1:0] data_hi_q;
    logic [DATA_W-1:0] hold_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] ram_q;
    logic              ram_we;
    logic              host_grant;
    logic              host_srq;
    logic              cp_srq;

    // Purpose: one write strobe per register select.
    for (genvar gi = 0; gi < N_REGS; gi++) begin : g_wr_dec
        assign wr_hit[gi] = bus_wr && (bus_addr == 3'(gi));
    end

    assign rd_data_hi = bus_rd && (bus_addr == SEL_DATA_HI);
    assign ram_we     = wr_hit[SEL_DATA_LO] && host_grant;

    // Purpose: address halves and the pending upper data half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_hi_q <= '0;
            addr_lo_q <= '0;
            data_hi_q <= '0;
        end else begin
            if (wr_hit[SEL_ADDR_HI]) addr_hi_q <= bus_wdata;
            if (wr_hit[SEL_ADDR_LO]) addr_lo_q <= bus_wdata;
            if (wr_hit[SEL_DATA_HI]) data_hi_q <= bus_wdata;
        end
    end

    // Purpose: capture the whole word on a high-half read for a coherent low read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (rd_data_hi) begin
            hold_q <= host_grant ? ram_q : '0;
        end
    end

    // Purpose: coprocessor control latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET[CTRL_W-1:0];
        end else if (wr_hit[SEL_CTRL]) begin
            ctrl_q <= bus_wdata[CTRL_W-1:0];
        end
    end

    assign cp_reset = ctrl_q[CTRL_RST_BIT];
    assign cp_ei2   = ctrl_q[CTRL_EI2_BIT];
    assign cp_hold  = ctrl_q[CTRL_HOLD_BIT];
    assign cp_boot  = ctrl_q[CTRL_BOOT_BIT];

    hdb_dpram #(
        .ADDR_W (MEM_AW),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (addr_lo_q[MEM_AW-1:0]),
        .wdata ({data_hi_q, bus_wdata}),
        .q     (ram_q)
    );

    hdb_sem u_sem (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_wr     (wr_hit[SEL_SEM]),
        .req_val    (bus_wdata[0]),
        .cp_req     (cp_mem_req),
        .host_grant (host_grant),
        .cp_grant   (cp_mem_grant)
    );

    hdb_mbox u_mbox (
        .clk          (clk),
        .rst_n        (rst_n),
        .srq_wr       (wr_hit[SEL_SRQ]),
        .srq_val      (bus_wdata[0]),
        .cp_ack       (cp_srq_ack),
        .ack_wr       (wr_hit[SEL_ACK]),
        .cp_req_pulse (cp_srq_req),
        .host_srq     (host_srq),
        .cp_srq       (cp_srq)
    );

    assign cp_srq_out = host_srq;
    assign host_irq   = cp_srq;

    // Purpose: read multiplexer, zero outside a read strobe.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                SEL_ADDR_HI: bus_rdata = addr_hi_q;
                SEL_ADDR_LO: bus_rdata = addr_lo_q;
                SEL_DATA_HI: bus_rdata = host_grant ? ram_q[DATA_W-1:HALF_W] : '0;
                SEL_DATA_LO: bus_rdata = host_grant ? hold_q[HALF_W-1:0] : '0;
                SEL_CTRL:    bus_rdata = {{(HALF_W-CTRL_W){1'b0}}, ctrl_q};
                SEL_SEM:     bus_rdata = {{(HALF_W-1){1'b0}}, host_grant};
                SEL_SRQ:     bus_rdata = {{(HALF_W-2){1'b0}}, cp_srq, host_srq};
                default:     bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/hdb_bridge_chk.sv
// Module: property checker for hostdsp_bridge, attached by bind below.
// Assumes: it observes only ports and the internal host grant.
module hdb_bridge_chk #(
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [3:1]        bus_addr,
    input logic [HALF_W-1:0] bus_wdata,
    input logic [HALF_W-1:0] bus_rdata,
    input logic              cp_mem_req,
    input logic              cp_srq_ack,
    input logic              cp_srq_req,
    input logic              cp_reset,
    input logic              cp_ei2,
    input logic              cp_hold,
    input logic              cp_boot,
    input logic              cp_mem_grant,
    input logic              cp_srq_out,
    input logic              host_irq,
    input logic              host_grant
);
    assert_exclusive_owner_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_grant && cp_mem_grant));

    assert_release_drops_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd5 && !bus_wdata[0]) |=> !host_grant);

    assert_cp_blocks_host_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_mem_req && !host_grant) |=> !host_grant);

    assert_host_keeps_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_grant && !(bus_wr && bus_addr == 3'd5)) |=> (host_grant && !cp_mem_grant));

    assert_ack_clears_srq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_srq_ack && !(bus_wr && bus_addr == 3'd6)) |=> !cp_srq_out);

    assert_cp_request_sets_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cp_srq_req |=> host_irq);

    assert_ctrl_reset_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd4) |=> (cp_reset == $past(bus_wdata[0])
                                          && cp_ei2 == $past(bus_wdata[4])
                                          && cp_hold == $past(bus_wdata[5])
                                          && cp_boot == $past(bus_wdata[7])));

    assert_no_grant_reads_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == 3'd2 || bus_addr == 3'd3) && !host_grant) |-> (bus_rdata == '0));

    assert_idle_bus_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |-> (bus_rdata == '0));
endmodule

bind hostdsp_bridge hdb_bridge_chk #(.HALF_W(HALF_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .cp_mem_req   (cp_mem_req),
    .cp_srq_ack   (cp_srq_ack),
    .cp_srq_req   (cp_srq_req),
    .cp_reset     (cp_reset),
    .cp_ei2       (cp_ei2),
    .cp_hold      (cp_hold),
    .cp_boot      (cp_boot),
    .cp_mem_grant (cp_mem_grant),
    .cp_srq_out   (cp_srq_out),
    .host_irq     (host_irq),
    .host_grant   (host_grant)
);

// File: tb/sim_hostdsp_bridge.sv
module sim_hostdsp_bridge;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:1]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        cp_mem_req = 1'b0;
    logic        cp_srq_ack = 1'b0;
    logic        cp_srq_req = 1'b0;
    logic        cp_reset, cp_ei2, cp_hold, cp_boot;
    logic        cp_mem_grant, cp_srq_out, host_irq;

    int checks = 0;
    int errors = 0;
    bit cp_level = 1'b0;
    logic [15:0] last_rd;

    // reference model state
    int unsigned m_addr_hi, m_addr_lo, m_dhi, m_hold, m_ctrl, m_ramq;
    int          m_owner;  // 0 free, 1 host, 2 coprocessor
    bit          m_want, m_hsrq, m_csrq;
    int unsigned m_mem [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    hostdsp_bridge u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cp_mem_req(cp_mem_req), .cp_srq_ack(cp_srq_ack), .cp_srq_req(cp_srq_req),
        .cp_reset(cp_reset), .cp_ei2(cp_ei2), .cp_hold(cp_hold), .cp_boot(cp_boot),
        .cp_mem_grant(cp_mem_grant), .cp_srq_out(cp_srq_out), .host_irq(host_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int unsigned model_read(input int off);
        case (off)
            0:  return m_addr_hi;
            2:  return m_addr_lo;
            4:  return (m_owner == 1) ? (m_ramq >> 16) : 0;
            6:  return (m_owner == 1) ? (m_hold & 32'hFFFF) : 0;
            8:  return m_ctrl;
            10: return (m_owner == 1) ? 1 : 0;
            12: return {30'd0, m_csrq, m_hsrq};
            default: return 0;
        endcase
    endfunction

    function automatic string read_tag(input int off);
        case (off)
            0, 2:  return "R1 R2 address readback";
            4, 6:  return (m_owner == 1) ? "R1 R4 data read" : "R5 ungranted read";
            8:     return "R6 control readback";
            10:    return "R7 semaphore read";
            12:    return "R9 R10 mailbox read";
            default: return "R1 acknowledge read";
        endcase
    endfunction

    task automatic model_reset();
        m_addr_hi = 0; m_addr_lo = 0; m_dhi = 0; m_hold = 0; m_ctrl = 32'h13;
        m_owner = 0; m_want = 0; m_hsrq = 0; m_csrq = 0;
    endtask

    task automatic model_edge(input bit wr, input bit rd, input int off, input int unsigned d,
                              input bit ack, input bit srq, input bit cpr);
        int unsigned idx = m_addr_lo & 32'h7FF;
        int unsigned new_q = m_mem.exists(int'(idx)) ? m_mem[int'(idx)] : 0;
        bit want_n = (wr && off == 10) ? d[0] : m_want;
        int own_n;
        if (rd && off == 4) m_hold = (m_owner == 1) ? m_ramq : 0;
        if (wr) begin
            case (off)
                0:  m_addr_hi = d;
                2:  m_addr_lo = d;
                4:  m_dhi = d;
                6:  if (m_owner == 1) m_mem[int'(idx)] = (m_dhi << 16) | d;
                8:  m_ctrl = d & 32'hFF;
                default: ;
            endcase
        end
        if (wr && off == 12) m_hsrq = d[0];
        else if (ack)        m_hsrq = 1'b0;
        if (srq)                  m_csrq = 1'b1;
        else if (wr && off == 14) m_csrq = 1'b0;
        case (m_owner)
            0: own_n = cpr ? 2 : (want_n ? 1 : 0);
            1: own_n = want_n ? 1 : (cpr ? 2 : 0);
            default: own_n = cpr ? 2 : (want_n ? 1 : 0);
        endcase
        m_owner = own_n;
        m_want  = want_n;
        m_ramq  = new_q;
    endtask

    task automatic compare_outputs();
        chk("R6 cp_reset", cp_reset, m_ctrl[0]);
        chk("R6 cp_ei2",   cp_ei2,   m_ctrl[4]);
        chk("R6 cp_hold",  cp_hold,  m_ctrl[5]);
        chk("R6 cp_boot",  cp_boot,  m_ctrl[7]);
        chk("R8 cp_mem_grant", cp_mem_grant, (m_owner == 2));
        chk("R9 cp_srq_out", cp_srq_out, m_hsrq);
        chk("R10 host_irq", host_irq, m_csrq);
    endtask

    // one bus cycle: drive at falling edge, judge reads before the edge,
    // advance the model at the edge, judge outputs after it
    task automatic step(input bit wr, input bit rd, input int off, input int unsigned d,
                        input bit ack, input bit srq);
        @(negedge clk);
        bus_wr = wr; bus_rd = rd; bus_addr = 3'(off / 2); bus_wdata = d[15:0];
        cp_srq_ack = ack; cp_srq_req = srq; cp_mem_req = cp_level;
        #1;
        last_rd = bus_rdata;
        chk(read_tag(off), bus_rdata, rd ? model_read(off) : 0);
        @(posedge clk);
        model_edge(wr, rd, off, d, ack, srq, cp_level);
        #1;
        compare_outputs();
    endtask

    task automatic wr_reg(input int off, input int unsigned d);
        step(1, 0, off, d, 0, 0);
    endtask
    task automatic idle();
        step(0, 0, 0, 0, 0, 0);
    endtask
    task automatic rd_expect(input int off, input logic [15:0] exp, input string tag);
        step(0, 1, off, 0, 0, 0);
        chk(tag, last_rd, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state
        chk("R6 reset cp_reset", cp_reset, 1'b1);
        chk("R6 reset cp_ei2", cp_ei2, 1'b1);
        chk("R8 reset cp_mem_grant", cp_mem_grant, 1'b0);
        rd_expect(8, 16'h0013, "R6 reset control value");
        rd_expect(10, 16'h0000, "R7 reset no grant");

        // control latch patterns
        wr_reg(8, 16'h12);
        chk("R6 run value reset low", cp_reset, 1'b0);
        wr_reg(8, 16'h00);
        wr_reg(8, 16'hB1);
        chk("R6 boot bit", cp_boot, 1'b1);
        rd_expect(8, 16'h00B1, "R6 readback");
        rd_expect(14, 16'h0000, "R1 acknowledge reads zero");

        // grant, write, release, ignored write, re-grant, read back
        wr_reg(10, 1);
        rd_expect(10, 16'h0001, "R7 host granted");
        wr_reg(0, 16'h0000); wr_reg(2, 16'h0007);
        wr_reg(4, 16'h1111); wr_reg(6, 16'h2222);
        wr_reg(10, 0);
        rd_expect(10, 16'h0000, "R7 released");
        wr_reg(4, 16'h9999); wr_reg(6, 16'h8888);
        rd_expect(4, 16'h0000, "R5 ungranted high read");
        rd_expect(6, 16'h0000, "R5 ungranted low read");
        wr_reg(10, 1);
        idle(); idle();
        rd_expect(4, 16'h1111, "R3 R5 committed high half kept");
        rd_expect(6, 16'h2222, "R3 R5 committed low half kept");

        // coherence: memory changes between the two halves
        wr_reg(4, 16'hAAAA); wr_reg(6, 16'hBBBB);
        idle(); idle();
        rd_expect(4, 16'hAAAA, "R4 high half");
        wr_reg(4, 16'hCCCC); wr_reg(6, 16'hDDDD);
        rd_expect(6, 16'hBBBB, "R4 low half coherent");
        idle(); idle();
        rd_expect(4, 16'hCCCC, "R3 new word high");
        rd_expect(6, 16'hDDDD, "R3 new word low");

        // high address half and bits above the index do not select
        wr_reg(0, 16'hABCD); wr_reg(2, 16'h0803);
        wr_reg(4, 16'h3333); wr_reg(6, 16'h4444);
        wr_reg(0, 16'h0000); wr_reg(2, 16'h0003);
        idle(); idle();
        rd_expect(4, 16'h3333, "R2 index from low 11 bits");
        rd_expect(6, 16'h4444, "R2 index low half");
        rd_expect(2, 16'h0003, "R2 low address readback");

        // simultaneous claim: coprocessor wins
        wr_reg(10, 0);
        cp_level = 1'b1;
        wr_reg(10, 1);
        chk("R8 coprocessor wins tie", cp_mem_grant, 1'b1);
        rd_expect(10, 16'h0000, "R11 host denied while coprocessor owns");
        rd_expect(4, 16'h0000, "R5 read while coprocessor owns");
        cp_level = 1'b0;
        idle();
        rd_expect(10, 16'h0001, "R8 host granted after release");
        cp_level = 1'b1;
        idle(); idle();
        chk("R8 host keeps grant", cp_mem_grant, 1'b0);
        rd_expect(10, 16'h0001, "R8 host still granted");
        wr_reg(10, 0);
        chk("R8 coprocessor takes over", cp_mem_grant, 1'b1);
        cp_level = 1'b0;
        idle();

        // mailbox, both directions and the collisions
        wr_reg(12, 1);
        rd_expect(12, 16'h0001, "R9 host request pending");
        step(0, 0, 0, 0, 1, 0);
        rd_expect(12, 16'h0000, "R9 acknowledge clears");
        step(1, 0, 12, 1, 1, 0);
        rd_expect(12, 16'h0001, "R9 write beats acknowledge");
        wr_reg(12, 0);
        step(0, 0, 0, 0, 0, 1);
        rd_expect(12, 16'h0002, "R10 coprocessor request pending");
        wr_reg(14, 16'h5A5A);
        rd_expect(12, 16'h0000, "R10 acknowledge write clears");
        step(1, 0, 14, 0, 0, 1);
        rd_expect(12, 16'h0002, "R10 request beats clear");
        wr_reg(14, 0);
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule